// File: doc/BRIEF.md
# Port Activity Status Formatter

This block builds, for each of eight network ports, the small group of bits that the port contributes to a serial LED frame. A shared 4-bit format code selects the group's layout. A layout holds between one and six software status bits. It can also hold either a single merged activity bit or separate transmit and receive activity bits, and these come first. The block hands the group and its length to a separate shift-chain controller, which sends the groups in port order. That controller also produces the latch strobe that marks each frame.

Activity inputs are one-cycle-or-longer pulses. A transmit pulse means the port is sending packet data or extension. A receive pulse means the port saw a non-idle cycle. Each pulse is caught in a sticky flag, so even a single-cycle event stays visible for at least one full blink period. The blink period is a programmable number of latch strobes. The block also drives the blink phase, which toggles at every period boundary.

Top module: `port_status_formatter`

## Requirements
- R1: After a synchronous active-low reset the format code is 0, every status register is 0, the blink rate is 1, all activity flags are clear and the blink phase is 0, so every port shows a group of length 1 with value 0.
- R2: Format codes 0, 1, 2 and 3 give status bits [0], [1:0], [3:0] and [5:0] of that port, with lengths 1, 2, 4 and 6; status bit 0 sits at group position 0, which is shifted first.
- R3: Format codes 4, 5 and 6 put the merged flag (TX flag OR RX flag) at position 0, followed by status bits [0], [1:0] and [3:0]; the lengths are 2, 3 and 5.
- R4: Format codes 8, 9 and 10 put the TX flag at position 0 and the RX flag at position 1, followed by status bits [0], [1:0] and [3:0]; the lengths are 4-bit-group lengths 3, 4 and 6.
- R5: Format codes 7 and 11 to 15 give length 0 and an all-zero group for every port.
- R6: Group bits at positions equal to or above the reported length are always 0.
- R7: A status write changes only the register of the selected port. The new value shows in the group from the next cycle, and so does a new format code.
- R8: A period boundary occurs on a latch strobe once the strobe counter reaches the blink rate minus one. The counter then restarts and the phase toggles. The phase changes at no other time, and a rate of 0 acts as a rate of 1.
- R9: An activity pulse sets that port's TX or RX flag in the next cycle.
- R10: A flag is cleared only at a period boundary at which no activity for it arrived during the period just ended, nor in the boundary cycle itself. A single pulse therefore stays visible through at least one complete period after the one in which it arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_we | input | 1 | Write strobe for the format code |
| fmt_wdata | input | 4 | New format code |
| stat_we | input | 1 | Write strobe for one port's status register |
| stat_sel | input | 3 | Port index for the status write |
| stat_wdata | input | 6 | New status value |
| rate_we | input | 1 | Write strobe for the blink rate |
| rate_wdata | input | 8 | New blink rate in latch strobes |
| latch_stb | input | 1 | One-cycle frame latch strobe from the shift-chain controller |
| tx_act | input | 8 | Per-port transmit activity pulses |
| rx_act | input | 8 | Per-port receive activity pulses |
| grp_bits | output | 48 | Per-port group, port p in bits [6p+5:6p], position 0 shifted first |
| grp_len | output | 24 | Per-port group length, port p in bits [3p+2:3p] |
| blink_phase | output | 1 | Blink phase, toggling at each period boundary |

## Verification
A wrong format decode shows at once, in the same cycle, as a wrong length or bit pattern on every port. A status register that is written to the wrong port shows one cycle after the write. A wrong strobe counter shows as a phase edge on the wrong latch strobe. A flag that is dropped too early or held too long shows only at a period boundary, so the bench runs each port's flags through several periods. It compares every group against a reference model on every cycle.

// File: rtl/pfmt_pkg.sv
// Package: shared layout type and format-code decode for the port status
// formatter. Assumes a 4-bit format code; codes outside the defined set
// decode to an empty layout.
package pfmt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_MERGED = 2'd1,
        ACT_SPLIT  = 2'd2
    } act_mode_e;

    typedef struct packed {
        logic      valid;
        act_mode_e act;
        logic [2:0] n_stat;
    } layout_t;

    // Low two code bits choose the status depth, upper two the activity style.
    function automatic layout_t decode_fmt(input logic [3:0] code);
        layout_t l;
        l.valid = 1'b1;
        case (code[1:0])
            2'd0:    l.n_stat = 3'd1;
            2'd1:    l.n_stat = 3'd2;
            2'd2:    l.n_stat = 3'd4;
            default: l.n_stat = 3'd6;
        endcase
        case (code[3:2])
            2'd0:    l.act = ACT_NONE;
            2'd1:    l.act = ACT_MERGED;
            2'd2:    l.act = ACT_SPLIT;
            default: l.act = ACT_NONE;
        endcase
        if (code[3:2] == 2'd3 || (code[3:2] != 2'd0 && code[1:0] == 2'd3)) begin
            l.valid  = 1'b0;
            l.act    = ACT_NONE;
            l.n_stat = 3'd0;
        end
        return l;
    endfunction

endpackage

// File: rtl/pfmt_blink.sv
// Module: blink period timer. Counts latch strobes and flags a period
// boundary once the count reaches rate-1; the phase toggles there.
// Assumes latch_stb is a one-cycle pulse; a rate of 0 behaves as 1.
module pfmt_blink #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_stb,
    input  logic [RATE_W-1:0] rate,
    output logic              boundary,
    output logic              phase
);

    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] rate_eff;

    // Effective rate and boundary detect; a count above the limit (rate lowered) ends the period at once.
    always_comb begin
        rate_eff = (rate == '0) ? RATE_W'(1) : rate;
        boundary = latch_stb && (cnt_q >= rate_eff - RATE_W'(1));
    end

    // Strobe counter and phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (boundary) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else if (latch_stb) begin
            cnt_q <= cnt_q + RATE_W'(1);
        end
    end

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> $stable(phase));

    assert_fast_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && rate <= RATE_W'(1)) |=> !$stable(phase));

endmodule

// File: rtl/pfmt_stretch.sv
// Module: activity pulse stretcher for one direction of one port.
// Sets a visible flag on any activity and clears it only at a period
// boundary that closes a period with no activity. Assumes boundary is a
// one-cycle pulse from the blink timer.
module pfmt_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic boundary,
    output logic shown
);

    logic seen_q;

    // Track activity within the current period and the flag shown to the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            shown  <= 1'b0;
        end else begin
            seen_q <= act | (boundary ? 1'b0 : seen_q);
            shown  <= act | (boundary ? seen_q : shown);
        end
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> shown);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shown && !boundary) |=> shown);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !act && !seen_q) |=> !shown);

endmodule

// File: rtl/pfmt_group.sv
// Module: builds one port's group from the decoded layout, the status
// register and the stretched activity flags. Purely combinational.
// Assumes the group width equals the status width, which holds for the
// widest layouts (six status bits, or two activity plus four status).
module pfmt_group
    import pfmt_pkg::*;
#(
    parameter int STAT_W = 6,
    parameter int LEN_W  = 3
) (
    input  layout_t           lay,
    input  logic [STAT_W-1:0] stat,
    input  logic              tx_show,
    input  logic              rx_show,
    output logic [STAT_W-1:0] bits,
    output logic [LEN_W-1:0]  len
);

    logic [STAT_W-1:0] act_v;
    logic [1:0]        n_act;
    logic [STAT_W-1:0] stat_mask;

    // Activity prefix, masked status, and assembled group.
    always_comb begin
        act_v = '0;
        n_act = 2'd0;
        case (lay.act)
            ACT_MERGED: begin
                act_v[0] = tx_show | rx_show;
                n_act    = 2'd1;
            end
            ACT_SPLIT: begin
                act_v[0] = tx_show;
                act_v[1] = rx_show;
                n_act    = 2'd2;
            end
            default: begin
                act_v = '0;
                n_act = 2'd0;
            end
        endcase
        stat_mask = ~({STAT_W{1'b1}} << lay.n_stat);
        bits      = ((stat & stat_mask) << n_act) | act_v;
        len       = LEN_W'(n_act) + LEN_W'(lay.n_stat);
    end

endmodule

// File: rtl/port_status_formatter.sv
// Module: top of the port status formatter. Holds the format code, the
// per-port status registers and the blink rate. Instantiates the blink
// timer, two stretchers per port and one group builder per port.
// Assumes single-cycle write strobes and a latch strobe from the chain
// controller; port p's group sits in slice p of the packed outputs.
module port_status_formatter
    import pfmt_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int STAT_W    = 6,
    parameter int RATE_W    = 8,
    parameter int FMT_W     = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 fmt_we,
    input  logic [FMT_W-1:0]                     fmt_wdata,
    input  logic                                 stat_we,
    input  logic [$clog2(NUM_PORTS)-1:0]         stat_sel,
    input  logic [STAT_W-1:0]                    stat_wdata,
    input  logic                                 rate_we,
    input  logic [RATE_W-1:0]                    rate_wdata,
    input  logic                                 latch_stb,
    input  logic [NUM_PORTS-1:0]                 tx_act,
    input  logic [NUM_PORTS-1:0]                 rx_act,
    output logic [NUM_PORTS*STAT_W-1:0]          grp_bits,
    output logic [NUM_PORTS*$clog2(STAT_W+1)-1:0] grp_len,
    output logic                                 blink_phase
);

    localparam int SEL_W = $clog2(NUM_PORTS);
    localparam int LEN_W = $clog2(STAT_W + 1);

    logic [FMT_W-1:0]  fmt_q;
    logic [RATE_W-1:0] rate_q;
    logic [STAT_W-1:0] stat_q [NUM_PORTS];
    logic              boundary;
    layout_t           lay;

    // Format code and blink rate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= '0;
            rate_q <= RATE_W'(1);
        end else begin
            if (fmt_we)  fmt_q  <= fmt_wdata;
            if (rate_we) rate_q <= rate_wdata;
        end
    end

    // Shared layout decode for all ports.
    always_comb lay = decode_fmt(4'(fmt_q));

    pfmt_blink #(.RATE_W(RATE_W)) blink_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_stb (latch_stb),
        .rate      (rate_q),
        .boundary  (boundary),
        .phase     (blink_phase)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic              tx_show;
        logic              rx_show;
        logic [STAT_W-1:0] bits_p;
        logic [LEN_W-1:0]  len_p;

        // Status register of this port, written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[p] <= '0;
            else if (stat_we && stat_sel == SEL_W'(p))
                stat_q[p] <= stat_wdata;
        end

        pfmt_stretch tx_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (tx_act[p]),
            .boundary (boundary),
            .shown    (tx_show)
        );

        pfmt_stretch rx_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (rx_act[p]),
            .boundary (boundary),
            .shown    (rx_show)
        );

        pfmt_group #(.STAT_W(STAT_W), .LEN_W(LEN_W)) grp_i (
            .lay     (lay),
            .stat    (stat_q[p]),
            .tx_show (tx_show),
            .rx_show (rx_show),
            .bits    (bits_p),
            .len     (len_p)
        );

        // Place this port's group in its output slice.
        always_comb begin
            grp_bits[p*STAT_W +: STAT_W] = bits_p;
            grp_len[p*LEN_W +: LEN_W]    = len_p;
        end

        assert_stat_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we && stat_sel != SEL_W'(p)) |=> $stable(stat_q[p]));

        assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            len_p <= LEN_W'(STAT_W));

        assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bits_p >> len_p) == '0);
    end

    assert_invalid_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_W'(7) || fmt_q >= FMT_W'(11)) |-> (grp_len == '0 && grp_bits == '0));

endmodule

// File: tb/port_status_formatter_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, compared every
// cycle against a reference model written from the requirements.
module port_status_formatter_tb_top;

    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fmt_we, stat_we, rate_we, latch_stb;
    logic [3:0]  fmt_wdata;
    logic [2:0]  stat_sel;
    logic [5:0]  stat_wdata;
    logic [7:0]  rate_wdata;
    logic [NP-1:0] tx_act, rx_act;
    logic [NP*6-1:0] grp_bits;
    logic [NP*3-1:0] grp_len;
    logic        blink_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    port_status_formatter dut_i (
        .clk(clk), .rst_n(rst_n),
        .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .stat_we(stat_we), .stat_sel(stat_sel), .stat_wdata(stat_wdata),
        .rate_we(rate_we), .rate_wdata(rate_wdata),
        .latch_stb(latch_stb), .tx_act(tx_act), .rx_act(rx_act),
        .grp_bits(grp_bits), .grp_len(grp_len), .blink_phase(blink_phase)
    );

    // Reference model state
    logic [3:0] m_fmt, n_fmt;
    logic [7:0] m_rate, n_rate, m_cnt, n_cnt;
    logic       m_phase, n_phase;
    logic [5:0] m_stat [NP];
    logic [5:0] n_stat [NP];
    logic [NP-1:0] m_tshow, m_rshow, m_tseen, m_rseen;
    logic [NP-1:0] n_tshow, n_rshow, n_tseen, n_rseen;

    function automatic void exp_group(input logic [3:0] f, input logic [5:0] s,
                                      input logic t, input logic r,
                                      output logic [5:0] b, output logic [2:0] l);
        logic a;
        a = t | r;
        case (f)
            4'h0: begin l = 3'd1; b = {5'b0, s[0]}; end
            4'h1: begin l = 3'd2; b = {4'b0, s[1:0]}; end
            4'h2: begin l = 3'd4; b = {2'b0, s[3:0]}; end
            4'h3: begin l = 3'd6; b = s; end
            4'h4: begin l = 3'd2; b = {4'b0, s[0], a}; end
            4'h5: begin l = 3'd3; b = {3'b0, s[1:0], a}; end
            4'h6: begin l = 3'd5; b = {1'b0, s[3:0], a}; end
            4'h8: begin l = 3'd3; b = {3'b0, s[0], r, t}; end
            4'h9: begin l = 3'd4; b = {2'b0, s[1:0], r, t}; end
            4'hA: begin l = 3'd6; b = {s[3:0], r, t}; end
            default: begin l = 3'd0; b = 6'd0; end
        endcase
    endfunction

    function automatic string fmt_tag(input logic [3:0] f);
        if (f <= 4'h3) return "R2";
        if (f <= 4'h6) return "R3";
        if (f >= 4'h8 && f <= 4'hA) return "R4";
        return "R5";
    endfunction

    // Next model state from current model and the inputs about to be sampled.
    task automatic model_next();
        logic [7:0] eff;
        logic bnd;
        n_fmt = m_fmt; n_rate = m_rate; n_cnt = m_cnt; n_phase = m_phase;
        for (int p = 0; p < NP; p++) n_stat[p] = m_stat[p];
        if (!rst_n) begin
            n_fmt = 4'd0; n_rate = 8'd1; n_cnt = 8'd0; n_phase = 1'b0;
            for (int p = 0; p < NP; p++) n_stat[p] = 6'd0;
            n_tshow = '0; n_rshow = '0; n_tseen = '0; n_rseen = '0;
        end else begin
            eff = (m_rate == 8'd0) ? 8'd1 : m_rate;
            bnd = latch_stb && (m_cnt >= eff - 8'd1);
            if (fmt_we)  n_fmt = fmt_wdata;
            if (rate_we) n_rate = rate_wdata;
            if (stat_we) n_stat[stat_sel] = stat_wdata;
            if (bnd) begin n_cnt = 8'd0; n_phase = ~m_phase; end
            else if (latch_stb) n_cnt = m_cnt + 8'd1;
            n_tshow = tx_act | (bnd ? m_tseen : m_tshow);
            n_rshow = rx_act | (bnd ? m_rseen : m_rshow);
            n_tseen = tx_act | (bnd ? '0 : m_tseen);
            n_rseen = rx_act | (bnd ? '0 : m_rseen);
        end
    endtask

    task automatic check_all(input string tag);
        logic [5:0] eb;
        logic [2:0] el;
        string t;
        for (int p = 0; p < NP; p++) begin
            exp_group(m_fmt, m_stat[p], m_tshow[p], m_rshow[p], eb, el);
            t = (tag != "") ? tag : fmt_tag(m_fmt);
            checks++;
            if (grp_bits[p*6 +: 6] !== eb || grp_len[p*3 +: 3] !== el) begin
                errors++;
                $display("FAIL %s port %0d fmt %h: bits %b len %0d, expected bits %b len %0d",
                         t, p, m_fmt, grp_bits[p*6 +: 6], grp_len[p*3 +: 3], eb, el);
            end
        end
        checks++;
        if (blink_phase !== m_phase) begin
            errors++;
            $display("FAIL R8 phase: got %b expected %b", blink_phase, m_phase);
        end
    endtask

    // One clock: model follows the inputs, outputs are checked at the next negedge.
    task automatic run_cycle(input string tag);
        model_next();
        @(posedge clk);
        m_fmt = n_fmt; m_rate = n_rate; m_cnt = n_cnt; m_phase = n_phase;
        for (int p = 0; p < NP; p++) m_stat[p] = n_stat[p];
        m_tshow = n_tshow; m_rshow = n_rshow; m_tseen = n_tseen; m_rseen = n_rseen;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle_inputs();
        fmt_we = 0; stat_we = 0; rate_we = 0; latch_stb = 0;
        tx_act = '0; rx_act = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        fmt_wdata = 0; stat_sel = 0; stat_wdata = 0; rate_wdata = 0;
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        // R1: reset state
        repeat (3) run_cycle("R1");
        rst_n = 1'b1;
        run_cycle("R1");

        // R8: rate 0 behaves as 1, phase toggles every strobe
        rate_we = 1; rate_wdata = 8'd0; run_cycle("R8");
        rate_we = 0;
        for (int i = 0; i < 6; i++) begin
            latch_stb = 1; run_cycle("R8");
            latch_stb = 0; run_cycle("R8");
        end

        // R9 / R10: single pulse with merged format, rate 3
        fmt_we = 1; fmt_wdata = 4'h4; rate_we = 1; rate_wdata = 8'd3; run_cycle("R3");
        idle_inputs();
        tx_act[2] = 1; run_cycle("R9");
        tx_act = '0;
        for (int i = 0; i < 12; i++) begin
            latch_stb = 1; run_cycle("R10");
            latch_stb = 0; run_cycle("R10");
        end
        // R10: repeated activity on split format keeps flag alive
        fmt_we = 1; fmt_wdata = 4'h8; run_cycle("R4");
        fmt_we = 0;
        for (int i = 0; i < 16; i++) begin
            rx_act[5] = (i % 3 == 0); latch_stb = (i % 2 == 1); run_cycle("R10");
        end
        idle_inputs();

        // R7: status writes to each port, full-width format
        fmt_we = 1; fmt_wdata = 4'h3; run_cycle("R2");
        fmt_we = 0;
        for (int p = 0; p < NP; p++) begin
            stat_we = 1; stat_sel = 3'(p); stat_wdata = 6'($urandom); run_cycle("R7");
        end
        stat_we = 0;

        // R2-R5: every format code in turn
        for (int f = 0; f < 16; f++) begin
            fmt_we = 1; fmt_wdata = 4'(f); run_cycle("");
            fmt_we = 0; tx_act = NP'($urandom); run_cycle("");
            tx_act = '0; run_cycle("");
        end

        // R6: random traffic over all formats
        for (int i = 0; i < 4000; i++) begin
            idle_inputs();
            latch_stb = ($urandom % 4) == 0;
            for (int p = 0; p < NP; p++) begin
                tx_act[p] = ($urandom % 16) == 0;
                rx_act[p] = ($urandom % 16) == 0;
            end
            if ($urandom % 40 == 0) begin fmt_we = 1; fmt_wdata = 4'($urandom); end
            if ($urandom % 64 == 0) begin rate_we = 1; rate_wdata = 8'($urandom % 6); end
            if ($urandom % 8 == 0) begin
                stat_we = 1; stat_sel = 3'($urandom); stat_wdata = 6'($urandom);
            end
            run_cycle((i % 2 == 0) ? "R6" : "");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule